// File: doc/BRIEF.md
# Character Display Window Store

This block keeps the contents of a one-line dot-matrix character display. One store holds 48 eight-bit character codes. A second store holds 12 five-bit accessory-segment patterns. Each store has its own start pointer, and that pointer marks which entry appears on the leftmost display digit. Commands arrive one per cycle on a command stream. A command can do one of the following:

- write either store, at an explicit address or at the pointer with auto-increment;
- load both pointers;
- rotate either pointer, or both, by one place in either direction;
- set which data types are shown and on which digits.

For each of the 12 digits, the block outputs the character code to render and the accessory bits to light. Character codes go to a separate font stage. Scrolling never moves any data. It only advances the pointers, and the 12 read ports index the stores at the pointer plus the digit number, modulo each store's depth. The character store wraps at 48 and the accessory store wraps at 12.

The command input uses a valid/ready handshake. A command is taken on a rising clock edge when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever reset is not asserted, so the block never applies back-pressure. A sender can therefore hold `cmd_valid` for exactly one cycle per command. A command takes effect at the edge that accepts it, and the digit outputs show the new state right after that edge.

Top module: `glyph_window`

## Requirements
- R1: After reset, both pointers are 0 and every store entry is 0. Characters and accessory data are both disabled and the digit mask is all zero, so `digit_char_on`, `digit_code` and `digit_acc` are all zero.
- R2: A character write with `cmd_inc`=0 stores `cmd_char_data` at `cmd_char_addr` and leaves the pointer unchanged. An address of 48 or more is ignored.
- R3: A character write with `cmd_inc`=1 stores the data at the current character pointer and then adds one to the pointer. The pointer wraps from 47 to 0.
- R4: An accessory write follows the same two rules using `cmd_acc_addr`, `cmd_acc_data` and the accessory pointer. The pointer wraps from 11 to 0, and an explicit address of 12 or more is ignored.
- R5: A set-address command loads `cmd_char_addr` into the character pointer and `cmd_acc_addr` into the accessory pointer in the same edge. A value out of range for its store leaves that pointer unchanged.
- R6: Digit i (0 = leftmost, field bits [i*8 +: 8] and [i*5 +: 5]) takes character entry (char pointer + i) mod 48 and accessory entry (acc pointer + i) mod 12.
- R7: A shift command moves the character pointer only when `cmd_sel_m`=1, and the accessory pointer only when `cmd_sel_a`=1. When both are 0, nothing moves.
- R8: With `cmd_dir_right`=1, a shifted pointer adds one (47→0, 11→0). With `cmd_dir_right`=0, it subtracts one (0→47, 0→11).
- R9: A display-control command latches `cmd_sel_m`, `cmd_sel_a` and `cmd_digit_mask`. The settings behave as follows:
  - Digit i shows its character (`digit_char_on[i]`=1, code passed through) only when the latched m bit and mask bit i are both 1. Otherwise its code and on bit are 0.
  - Its accessory bits pass through only when the latched a bit and mask bit i are both 1. Otherwise they are 0.
- R10: `cmd_ready` is 0 during reset and 1 otherwise. A command with `cmd_valid`=0 has no effect. The `cmd_op` values are 0 none, 1 character write, 2 accessory write, 3 set address, 4 shift, and 5 display control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (high out of reset) |
| cmd_op | input | 3 | Command kind |
| cmd_inc | input | 1 | Auto-increment write mode |
| cmd_char_addr | input | 6 | Character address or pointer value |
| cmd_acc_addr | input | 4 | Accessory address or pointer value |
| cmd_char_data | input | 8 | Character code to write |
| cmd_acc_data | input | 5 | Accessory pattern to write |
| cmd_sel_m | input | 1 | Character data select (shift / display) |
| cmd_sel_a | input | 1 | Accessory data select (shift / display) |
| cmd_dir_right | input | 1 | Shift direction, 1 = pointer +1 |
| cmd_digit_mask | input | 12 | Per-digit enable, bit i = digit i |
| digit_code | output | 96 | Character code per digit |
| digit_char_on | output | 12 | Character shown per digit |
| digit_acc | output | 60 | Accessory bits per digit |

## Verification
The checks compare all 12 digits after every command. Three kinds of content pattern are used:

- Sparse writes at scattered addresses show whether explicit addressing, and the rejection of out-of-range addresses, reach the intended entry.
- A dense ramp of distinct codes makes every window position unique. Any off-by-one in the modulo indexing, or a shift in the wrong direction, then changes a visible digit.
- Pointer values placed just before each wrap point, followed by increments and shifts in both directions, show whether the character store wraps at 48 and the accessory store wraps at 12.

Masks with disjoint digit groups and mixed m/a selects separate the character gating from the accessory gating.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_WCHAR   = 3'd1,
    OP_WACC    = 3'd2,
    OP_SETADDR = 3'd3,
    OP_SHIFT   = 3'd4,
    OP_DISP    = 3'd5
  } glyph_op_e;

  typedef struct packed {
    logic show_char;
    logic show_acc;
  } glyph_sel_t;
endpackage

// File: rtl/glyph_ptr.sv
// Start pointer that wraps modulo DEPTH; loads reject out-of-range values.
module glyph_ptr #(
  parameter int DEPTH = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          inc_en,
  input  logic          dec_en,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_en) begin
      if (load_val <= LAST) ptr <= load_val;
    end else if (inc_en) begin
      ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
    end else if (dec_en) begin
      ptr <= (ptr == '0) ? LAST : ptr - AW'(1);
    end
  end
endmodule

// File: rtl/glyph_store.sv
// Register-file store: one write port, DIGITS combinational windowed read ports.
module glyph_store #(
  parameter int DEPTH  = 48,
  parameter int W      = 8,
  parameter int DIGITS = 12,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [W-1:0]        wdata,
  input  logic [AW-1:0]       base,
  output logic [DIGITS*W-1:0] rd_flat
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEP  = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we && (waddr <= LAST)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_rd
    localparam logic [AW:0] OFS = (AW+1)'(g);
    logic [AW:0] sum;
    logic [AW:0] idx;
    assign sum = {1'b0, base} + OFS;
    assign idx = (sum >= DEP) ? sum - DEP : sum;
    assign rd_flat[g*W +: W] = mem[idx[AW-1:0]];
  end
endmodule

// File: rtl/glyph_gate.sv
// Per-digit gating of character and accessory data by type select and digit mask.
module glyph_gate #(
  parameter int DIGITS = 12,
  parameter int CW     = 8,
  parameter int AWD    = 5
) (
  input  glyph_pkg::glyph_sel_t sel,
  input  logic [DIGITS-1:0]     mask,
  input  logic [DIGITS*CW-1:0]  char_flat,
  input  logic [DIGITS*AWD-1:0] acc_flat,
  output logic [DIGITS*CW-1:0]  code_flat,
  output logic [DIGITS-1:0]     char_on,
  output logic [DIGITS*AWD-1:0] acc_out
);
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic c_en;
    logic a_en;
    assign c_en = sel.show_char & mask[g];
    assign a_en = sel.show_acc & mask[g];
    assign char_on[g]            = c_en;
    assign code_flat[g*CW +: CW] = c_en ? char_flat[g*CW +: CW] : '0;
    assign acc_out[g*AWD +: AWD] = a_en ? acc_flat[g*AWD +: AWD] : '0;
  end
endmodule

// File: rtl/glyph_window.sv
module glyph_window #(
  parameter  int DIGITS     = 12,
  parameter  int CHAR_DEPTH = 48,
  parameter  int CHAR_W     = 8,
  parameter  int ACC_DEPTH  = 12,
  parameter  int ACC_W      = 5,
  localparam int CAW        = $clog2(CHAR_DEPTH),
  localparam int AAW        = $clog2(ACC_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic                     cmd_inc,
  input  logic [CAW-1:0]           cmd_char_addr,
  input  logic [AAW-1:0]           cmd_acc_addr,
  input  logic [CHAR_W-1:0]        cmd_char_data,
  input  logic [ACC_W-1:0]         cmd_acc_data,
  input  logic                     cmd_sel_m,
  input  logic                     cmd_sel_a,
  input  logic                     cmd_dir_right,
  input  logic [DIGITS-1:0]        cmd_digit_mask,
  output logic [DIGITS*CHAR_W-1:0] digit_code,
  output logic [DIGITS-1:0]        digit_char_on,
  output logic [DIGITS*ACC_W-1:0]  digit_acc
);
  import glyph_pkg::*;

  glyph_op_e  op;
  logic       fire;
  logic       is_wchar, is_wacc, is_load, is_shift, is_disp;
  logic [CAW-1:0] char_ptr;
  logic [AAW-1:0] acc_ptr;
  logic [CAW-1:0] char_waddr;
  logic [AAW-1:0] acc_waddr;
  logic       char_up, char_dn, acc_up, acc_dn;
  glyph_sel_t disp_sel;
  logic [DIGITS-1:0] disp_mask;
  logic [DIGITS*CHAR_W-1:0] char_rd;
  logic [DIGITS*ACC_W-1:0]  acc_rd;
  logic       disp_m, disp_a;

  assign cmd_ready = rst_n;
  assign fire      = cmd_valid & cmd_ready;
  assign op        = glyph_op_e'(cmd_op);
  assign is_wchar  = fire & (op == OP_WCHAR);
  assign is_wacc   = fire & (op == OP_WACC);
  assign is_load   = fire & (op == OP_SETADDR);
  assign is_shift  = fire & (op == OP_SHIFT);
  assign is_disp   = fire & (op == OP_DISP);

  assign char_waddr = cmd_inc ? char_ptr : cmd_char_addr;
  assign acc_waddr  = cmd_inc ? acc_ptr  : cmd_acc_addr;

  assign char_up = (is_wchar & cmd_inc) | (is_shift & cmd_sel_m & cmd_dir_right);
  assign char_dn = is_shift & cmd_sel_m & ~cmd_dir_right;
  assign acc_up  = (is_wacc & cmd_inc) | (is_shift & cmd_sel_a & cmd_dir_right);
  assign acc_dn  = is_shift & cmd_sel_a & ~cmd_dir_right;

  glyph_ptr #(.DEPTH(CHAR_DEPTH), .AW(CAW)) u_char_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(is_load), .load_val(cmd_char_addr),
    .inc_en(char_up), .dec_en(char_dn), .ptr(char_ptr)
  );

  glyph_ptr #(.DEPTH(ACC_DEPTH), .AW(AAW)) u_acc_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(is_load), .load_val(cmd_acc_addr),
    .inc_en(acc_up), .dec_en(acc_dn), .ptr(acc_ptr)
  );

  glyph_store #(.DEPTH(CHAR_DEPTH), .W(CHAR_W), .DIGITS(DIGITS), .AW(CAW)) u_char_store (
    .clk(clk), .rst_n(rst_n), .we(is_wchar), .waddr(char_waddr),
    .wdata(cmd_char_data), .base(char_ptr), .rd_flat(char_rd)
  );

  glyph_store #(.DEPTH(ACC_DEPTH), .W(ACC_W), .DIGITS(DIGITS), .AW(AAW)) u_acc_store (
    .clk(clk), .rst_n(rst_n), .we(is_wacc), .waddr(acc_waddr),
    .wdata(cmd_acc_data), .base(acc_ptr), .rd_flat(acc_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_sel  <= '0;
      disp_mask <= '0;
    end else if (is_disp) begin
      disp_sel.show_char <= cmd_sel_m;
      disp_sel.show_acc  <= cmd_sel_a;
      disp_mask          <= cmd_digit_mask;
    end
  end

  assign disp_m = disp_sel.show_char;
  assign disp_a = disp_sel.show_acc;

  glyph_gate #(.DIGITS(DIGITS), .CW(CHAR_W), .AWD(ACC_W)) u_gate (
    .sel(disp_sel), .mask(disp_mask), .char_flat(char_rd), .acc_flat(acc_rd),
    .code_flat(digit_code), .char_on(digit_char_on), .acc_out(digit_acc)
  );
endmodule

// File: rtl/glyph_window_chk.sv
module glyph_window_chk #(
  parameter int DIGITS     = 12,
  parameter int CHAR_DEPTH = 48,
  parameter int ACC_DEPTH  = 12,
  parameter int ACC_W      = 5,
  parameter int CAW        = $clog2(CHAR_DEPTH),
  parameter int AAW        = $clog2(ACC_DEPTH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [2:0]              cmd_op,
  input logic                    cmd_sel_m,
  input logic                    cmd_sel_a,
  input logic                    cmd_dir_right,
  input logic [CAW-1:0]          cmd_char_addr,
  input logic [CAW-1:0]          char_ptr,
  input logic [AAW-1:0]          acc_ptr,
  input logic                    disp_m,
  input logic                    disp_a,
  input logic [DIGITS-1:0]       digit_char_on,
  input logic [DIGITS*ACC_W-1:0] digit_acc
);
  import glyph_pkg::*;
  localparam logic [CAW-1:0] CLAST = CAW'(CHAR_DEPTH - 1);

  logic sh;
  assign sh = cmd_valid & cmd_ready & (cmd_op == OP_SHIFT);

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_ptr <= CLAST) && (acc_ptr < AAW'(ACC_DEPTH)));

  // R8
  char_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh && cmd_sel_m && cmd_dir_right) |=>
      char_ptr == (($past(char_ptr) == CLAST) ? '0 : $past(char_ptr) + CAW'(1)));

  // R8
  char_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh && cmd_sel_m && !cmd_dir_right) |=>
      char_ptr == (($past(char_ptr) == '0) ? CLAST : $past(char_ptr) - CAW'(1)));

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh && !cmd_sel_a) |=> $stable(acc_ptr));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_SETADDR && cmd_char_addr <= CLAST)
      |=> char_ptr == $past(cmd_char_addr));

  // R9
  char_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_m |-> digit_char_on == '0);

  // R9
  acc_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_a |-> digit_acc == '0);
endmodule

bind glyph_window glyph_window_chk #(
  .DIGITS(DIGITS), .CHAR_DEPTH(CHAR_DEPTH), .ACC_DEPTH(ACC_DEPTH), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_sel_m(cmd_sel_m), .cmd_sel_a(cmd_sel_a),
  .cmd_dir_right(cmd_dir_right), .cmd_char_addr(cmd_char_addr),
  .char_ptr(char_ptr), .acc_ptr(acc_ptr), .disp_m(disp_m), .disp_a(disp_a),
  .digit_char_on(digit_char_on), .digit_acc(digit_acc)
);

// File: tb/tb_glyph_window.sv
module tb_glyph_window;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 0;
  logic        cmd_inc = 0;
  logic [5:0]  cmd_char_addr = 0;
  logic [3:0]  cmd_acc_addr = 0;
  logic [7:0]  cmd_char_data = 0;
  logic [4:0]  cmd_acc_data = 0;
  logic        cmd_sel_m = 0, cmd_sel_a = 0, cmd_dir_right = 0;
  logic [11:0] cmd_digit_mask = 0;
  logic [95:0] digit_code;
  logic [11:0] digit_char_on;
  logic [59:0] digit_acc;

  always #2.5 clk = ~clk;

  glyph_window dut (.*);

  typedef struct packed {
    logic [95:0] code;
    logic [11:0] on;
    logic [59:0] acc;
  } snap_t;

  snap_t exp_q[$];
  string tag_q[$];
  int total = 0, bad = 0;

  // reference state built from the requirements
  logic [7:0] m_char [48];
  logic [4:0] m_acc  [12];
  int m_cp = 0, m_ap = 0;
  logic m_m = 0, m_a = 0;
  logic [11:0] m_mask = 0;

  function automatic snap_t expect_now();
    snap_t s;
    for (int i = 0; i < 12; i++) begin
      s.on[i]         = m_m & m_mask[i];
      s.code[i*8 +: 8] = s.on[i] ? m_char[(m_cp + i) % 48] : 8'h00;
      s.acc[i*5 +: 5]  = (m_a & m_mask[i]) ? m_acc[(m_ap + i) % 12] : 5'h00;
    end
    return s;
  endfunction

  task automatic push(string tag);
    exp_q.push_back(expect_now());
    tag_q.push_back(tag);
  endtask

  task automatic send(input int op, input bit inc, input int ca, input int aa,
                      input int cd, input int ad, input bit m, input bit a,
                      input bit dir, input logic [11:0] mask, input string tag,
                      input bit valid = 1'b1);
    @(negedge clk);
    cmd_valid = valid; cmd_op = 3'(op); cmd_inc = inc;
    cmd_char_addr = 6'(ca); cmd_acc_addr = 4'(aa);
    cmd_char_data = 8'(cd); cmd_acc_data = 5'(ad);
    cmd_sel_m = m; cmd_sel_a = a; cmd_dir_right = dir; cmd_digit_mask = mask;
    @(posedge clk);
    #1;
    cmd_valid = 0;
    if (valid) begin
      case (op)
        1: if (inc) begin m_char[m_cp] = 8'(cd); m_cp = (m_cp + 1) % 48; end
           else if (ca < 48) m_char[ca] = 8'(cd);
        2: if (inc) begin m_acc[m_ap] = 5'(ad); m_ap = (m_ap + 1) % 12; end
           else if (aa < 12) m_acc[aa] = 5'(ad);
        3: begin if (ca < 48) m_cp = ca; if (aa < 12) m_ap = aa; end
        4: begin
             if (m) m_cp = dir ? (m_cp + 1) % 48 : (m_cp + 47) % 48;
             if (a) m_ap = dir ? (m_ap + 1) % 12 : (m_ap + 11) % 12;
           end
        5: begin m_m = m; m_a = a; m_mask = mask; end
        default: ;
      endcase
    end
    push(tag);
  endtask

  // monitor: pops expected snapshots and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (digit_code !== e.code || digit_char_on !== e.on || digit_acc !== e.acc) begin
          bad++;
          $display("FAIL %s code=%h on=%h acc=%h expected code=%h on=%h acc=%h",
                   t, digit_code, digit_char_on, digit_acc, e.code, e.on, e.acc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 48; k++) m_char[k] = 0;
    for (int k = 0; k < 12; k++) m_acc[k] = 0;
    #3;
    total++;
    if (cmd_ready !== 1'b0) begin
      bad++; $display("FAIL R10 ready during reset actual=%b expected=0", cmd_ready);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    push("R1 reset outputs");
    @(negedge clk);
    total++;
    if (cmd_ready !== 1'b1) begin
      bad++; $display("FAIL R10 ready after reset actual=%b expected=1", cmd_ready);
    end

    // op: 1 char wr, 2 acc wr, 3 set addr, 4 shift, 5 display
    send(5, 0, 0, 0, 0, 0, 1, 1, 0, 12'hFFF, "R9 all on zero data");
    send(1, 0, 5, 0, 8'h41, 0, 0, 0, 0, 0, "R2 normal write addr5");
    send(1, 0, 47, 0, 8'hEE, 0, 0, 0, 0, 0, "R2 normal write addr47");
    send(1, 0, 50, 0, 8'h77, 0, 0, 0, 0, 0, "R2 out-of-range ignored");
    send(3, 0, 44, 10, 0, 0, 0, 0, 0, 0, "R5 load 44/10");
    send(1, 1, 0, 0, 8'h10, 0, 0, 0, 0, 0, "R3 inc write 44");
    send(1, 1, 0, 0, 8'h11, 0, 0, 0, 0, 0, "R3 inc write 45");
    send(1, 1, 0, 0, 8'h12, 0, 0, 0, 0, 0, "R3 inc write 46");
    send(1, 1, 0, 0, 8'h13, 0, 0, 0, 0, 0, "R3 inc write 47 wraps");
    send(2, 1, 0, 0, 0, 5'h11, 0, 0, 0, 0, "R4 inc acc 10");
    send(2, 1, 0, 0, 0, 5'h12, 0, 0, 0, 0, "R4 inc acc 11");
    send(2, 1, 0, 0, 0, 5'h13, 0, 0, 0, 0, "R4 inc acc wraps to 0");
    send(2, 0, 0, 3, 0, 5'h15, 0, 0, 0, 0, "R4 normal acc addr3");
    send(2, 0, 0, 13, 0, 5'h1F, 0, 0, 0, 0, "R4 acc out-of-range ignored");
    send(3, 0, 60, 14, 0, 0, 0, 0, 0, 0, "R5 out-of-range load ignored");
    for (int k = 0; k < 12; k++)
      send(1, 1, 0, 0, 8'h30 + k, 0, 0, 0, 0, 0, "R3 ramp fill");
    for (int k = 0; k < 12; k++)
      send(2, 1, 0, 0, 0, k + 1, 0, 0, 0, 0, "R4 ramp fill");
    send(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 window at 0/0");
    send(3, 0, 40, 7, 0, 0, 0, 0, 0, 0, "R6 window crossing wrap");
    send(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 load 0/0");
    send(4, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R7 shift char only right");
    send(4, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7 shift acc only left");
    send(4, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 shift none");
    send(4, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R8 both left");
    send(4, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R8 both left wraps char to 47");
    send(4, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R8 both right");
    send(3, 0, 47, 11, 0, 0, 0, 0, 0, 0, "R5 load 47/11");
    send(4, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R8 right wraps to 0/0");
    send(4, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R8 left wraps to 47/11");
    send(5, 0, 0, 0, 0, 0, 1, 0, 0, 12'h0F0, "R9 char only mask 0F0");
    send(5, 0, 0, 0, 0, 0, 0, 1, 0, 12'hF0F, "R9 acc only mask F0F");
    send(5, 0, 0, 0, 0, 0, 0, 0, 0, 12'hFFF, "R9 both off blank");
    send(5, 0, 0, 0, 0, 0, 1, 1, 0, 12'hFFF, "R9 both on");
    send(1, 0, 2, 0, 8'hAB, 0, 0, 0, 0, 0, "R10 write without valid", 1'b0);
    send(3, 0, 5, 5, 0, 0, 0, 0, 0, 0, "R10 load without valid", 1'b0);
    send(4, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R10 shift after idle");
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule